// File: doc/BRIEF.md
# Parallel I/O Bus Strobe Sequencer

This block sits behind a backplane slave decoder and turns one decoded bank access at a time into a timed cycle on a slow 8-bit parallel I/O bus. That bus has six bank-select lines, separate active-low read and write strobes, and a data byte that the block drives only while a write strobe is low. Every strobe is held low for a fixed number of clock cycles. After each strobe, a recovery interval of fixed length must pass before the next strobe may start.

Writes are posted. The bank and data byte are captured, the master gets its acknowledge two clock edges after the request is accepted, and the write strobe then runs on its own. Reads keep the master waiting until the strobe has finished and the byte has been captured. A request that arrives while a strobe or a recovery interval is still running is not accepted until the interval is over, so its acknowledge is delayed. The acknowledge always falls one edge after the master withdraws its request.

Top module: `pio_strobe_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, io_rd_n and io_wr_n are 1, io_doe is 0 and ack is 0.
- R2: A write request accepted from idle raises ack after the second rising edge that follows the request being raised. The strobe has not yet run at that point, so the write is posted.
- R3: A write drives io_wr_n low for exactly STROBE_CYC (default 32) cycles. During that time io_dout carries the written byte, and io_doe is 1 only while io_wr_n is 0.
- R4: A read drives io_rd_n low for exactly STROBE_CYC cycles. io_doe stays 0 throughout a read, and the two strobes are never low together.
- R5: Read data is sampled from io_din on the last cycle of the read strobe and held on rdata. From idle, ack rises after the (STROBE_CYC+2)th rising edge following the request.
- R6: Between the end of one strobe and the start of the next, both strobes stay high for at least RECOV_CYC (default 32) cycles.
- R7: A request raised while the block is in a strobe or a recovery interval is accepted only after that interval ends. With the defaults, a read raised right after a posted write is released gets ack after 97 edges.
- R8: When req_valid is 0 at a rising edge, ack is 0 after that edge.
- R9: An asserted reset at once releases both strobes and io_doe and discards a posted write in progress. No strobe follows after reset is released.
- R10: io_addr shows the accepted bank number, unchanged, for the whole length of each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Decoded access request, held by the master until it has seen ack |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_bank | input | 6 | Bank number of the access |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | Data-transfer acknowledge to the master (active high) |
| rdata | output | 8 | Last byte captured by a read |
| io_addr | output | 6 | Bank select lines of the I/O bus |
| io_rd_n | output | 1 | Read strobe, active low |
| io_wr_n | output | 1 | Write strobe, active low |
| io_dout | output | 8 | Byte driven onto the I/O data lines |
| io_doe | output | 1 | Output enable for io_dout |
| io_din | input | 8 | Byte read from the I/O data lines |

## Verification
The assertions assume a master that keeps req_valid high from the moment it raises a request until it sees ack, and that never withdraws a request early. The bench raises and lowers its request only on falling clock edges. It waits for ack before it drops the request, and it raises a new request only after ack has fallen. The one exception is the stall case, where the new request goes up during the busy window, which the block is required to handle. The read byte on io_din changes partway through the strobe, so that a capture taken too early shows up as a data mismatch.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WACK  = 3'd1,
    ST_STRB  = 3'd2,
    ST_RECOV = 3'd3,
    ST_RACK  = 3'd4,
    ST_WREL  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/pio_phase_timer.sv
module pio_phase_timer #(
  parameter int STROBE_CYC = 32,
  parameter int RECOV_CYC  = 32,
  localparam int CMAX = (STROBE_CYC > RECOV_CYC) ? STROBE_CYC : RECOV_CYC,
  localparam int CW   = (CMAX > 1) ? $clog2(CMAX) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic sel_recov,
  output logic done
);
  localparam logic [CW-1:0] LIM_S = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] LIM_R = CW'(RECOV_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = en && (cnt_q == (sel_recov ? LIM_R : LIM_S));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= (sel_recov ? LIM_R : LIM_S)));
endmodule

// File: rtl/pio_xact_latch.sv
module pio_xact_latch #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          wr_in,
  input  logic [AW-1:0] bank_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic          wr_q,
  output logic [AW-1:0] bank_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      bank_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      wr_q    <= wr_in;
      bank_q  <= bank_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (cap) rdata_q <= din;
  end

  // R10
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bank_q));
endmodule

// File: rtl/pio_bus_drive.sv
module pio_bus_drive #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          strobe_act,
  input  logic          wr_q,
  input  logic [AW-1:0] bank_q,
  input  logic [DW-1:0] wdata_q,
  output logic [AW-1:0] io_addr,
  output logic          io_rd_n,
  output logic          io_wr_n,
  output logic [DW-1:0] io_dout,
  output logic          io_doe
);
  always_comb begin
    io_addr = bank_q;
    io_dout = wdata_q;
    io_wr_n = !(strobe_act && wr_q);
    io_rd_n = !(strobe_act && !wr_q);
    io_doe  = strobe_act && wr_q;
  end
endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
  import pio_seq_pkg::*;
#(
  parameter int AW         = 6,
  parameter int DW         = 8,
  parameter int STROBE_CYC = 32,
  parameter int RECOV_CYC  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_bank,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] io_addr,
  output logic          io_rd_n,
  output logic          io_wr_n,
  output logic [DW-1:0] io_dout,
  output logic          io_doe,
  input  logic [DW-1:0] io_din
);
  seq_state_t state_q, state_d;
  logic ack_q, ack_d, ack_set;
  logic load, cap, tmr_done, tmr_en;
  logic wr_q;
  logic [AW-1:0] bank_q;
  logic [DW-1:0] wdata_q;

  assign tmr_en = (state_q == ST_STRB) || (state_q == ST_RECOV);

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    cap     = 1'b0;
    ack_set = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && !ack_q) begin
          load    = 1'b1;
          state_d = req_write ? ST_WACK : ST_STRB;
        end
      end
      ST_WACK: begin
        ack_set = 1'b1;
        state_d = ST_STRB;
      end
      ST_STRB: begin
        if (tmr_done) begin
          cap     = !wr_q;
          state_d = wr_q ? ST_RECOV : ST_RACK;
        end
      end
      ST_RACK: begin
        ack_set = 1'b1;
        state_d = ST_RECOV;
      end
      ST_RECOV: begin
        if (tmr_done) state_d = (ack_q && req_valid) ? ST_WREL : ST_IDLE;
      end
      ST_WREL: begin
        if (!req_valid) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ack_d = ack_q;
    if (!req_valid)   ack_d = 1'b0;
    else if (ack_set) ack_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  assign ack = ack_q;

  pio_phase_timer #(.STROBE_CYC(STROBE_CYC), .RECOV_CYC(RECOV_CYC)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (state_d != state_q),
    .en        (tmr_en),
    .sel_recov (state_q == ST_RECOV),
    .done      (tmr_done)
  );

  pio_xact_latch #(.AW(AW), .DW(DW)) i_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .wr_in    (req_write),
    .bank_in  (req_bank),
    .wdata_in (req_wdata),
    .cap      (cap),
    .din      (io_din),
    .wr_q     (wr_q),
    .bank_q   (bank_q),
    .wdata_q  (wdata_q),
    .rdata_q  (rdata)
  );

  pio_bus_drive #(.AW(AW), .DW(DW)) i_drive (
    .strobe_act (state_q == ST_STRB),
    .wr_q       (wr_q),
    .bank_q     (bank_q),
    .wdata_q    (wdata_q),
    .io_addr    (io_addr),
    .io_rd_n    (io_rd_n),
    .io_wr_n    (io_wr_n),
    .io_dout    (io_dout),
    .io_doe     (io_doe)
  );

  // R4
  strb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd_n || io_wr_n);
  // R3
  doe_in_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_doe |-> !io_wr_n);
  // R8
  ack_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !ack);
  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr_n && $past(!io_wr_n)) |-> $stable(io_addr));
  // R5
  ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(req_valid));
  // R6
  no_strb_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(!io_rd_n) || $rose(!io_wr_n)) |-> $past(state_q == ST_IDLE || state_q == ST_WACK));
endmodule

// File: tb/test_pio_strobe_seq.sv
module test_pio_strobe_seq;
  localparam int S = 32;
  localparam int R = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [5:0] req_bank = '0;
  logic [7:0] req_wdata = '0, io_din = '0;
  logic ack, io_rd_n, io_wr_n, io_doe;
  logic [7:0] rdata, io_dout;
  logic [5:0] io_addr;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pio_strobe_seq i_pio_strobe_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .io_addr(io_addr), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .io_dout(io_dout), .io_doe(io_doe), .io_din(io_din)
  );

  // bus monitor
  int wr_run = 0, rd_run = 0, gap_run = 0, min_gap = 100000, n_strobes = 0, oe_bad = 0;
  int last_wr_w = 0, last_rd_w = 0;
  logic [7:0] last_wdata = '0;
  logic [5:0] last_waddr = '0, last_raddr = '0;
  logic addr_bad = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      wr_run = 0; rd_run = 0; gap_run = 0;
    end else begin
      if (io_doe && io_wr_n) oe_bad++;
      if (io_doe && !io_rd_n) oe_bad++;
      if (!io_wr_n || !io_rd_n) begin
        if (wr_run == 0 && rd_run == 0) begin
          if (n_strobes > 0 && gap_run < min_gap) min_gap = gap_run;
          n_strobes++;
          gap_run = 0;
          addr_bad = 1'b0;
          last_waddr = io_addr;
          last_raddr = io_addr;
        end else if (io_addr != last_waddr) addr_bad = 1'b1;
        if (!io_wr_n) begin wr_run++; last_wdata = io_dout; end
        if (!io_rd_n) rd_run++;
      end else begin
        if (wr_run > 0) last_wr_w = wr_run;
        if (rd_run > 0) last_rd_w = rd_run;
        wr_run = 0; rd_run = 0;
        gap_run++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [5:0] bank, input logic [7:0] wd,
                        input logic [7:0] din, output int n);
    n = 0;
    req_write = wr; req_bank = bank; req_wdata = wd; req_valid = 1'b1;
    if (!wr) io_din = 8'h00;
    forever begin
      @(negedge clk);
      n++;
      if (n == S - 4 && !wr) io_din = din;
      if (ack || n > 500) break;
    end
  endtask

  task automatic release_req();
    req_valid = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R8 ack release", ack, 0);
  endtask

  // {write, bank, wdata, din}
  localparam logic [22:0] VEC [0:5] = '{
    {1'b1, 6'd12, 8'hA5, 8'h00},
    {1'b0, 6'd12, 8'h00, 8'h3C},
    {1'b1, 6'd63, 8'hFF, 8'h00},
    {1'b0, 6'd0,  8'h00, 8'hC3},
    {1'b1, 6'd1,  8'h00, 8'h00},
    {1'b0, 6'd42, 8'h00, 8'h81}
  };

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int snap;
    repeat (3) @(negedge clk);
    chk(io_rd_n && io_wr_n && !io_doe && !ack, "R1 in reset", {io_rd_n, io_wr_n, io_doe, ack}, 4'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(io_rd_n && io_wr_n && !io_doe && !ack, "R1 after reset", {io_rd_n, io_wr_n, io_doe, ack}, 4'b1100);

    for (int i = 0; i < 6; i++) begin
      logic wr; logic [5:0] bk; logic [7:0] wd, di;
      {wr, bk, wd, di} = VEC[i];
      access(wr, bk, wd, di, n);
      if (wr) begin
        chk(n == 2, "R2 write ack latency", n, 2);
        chk(wr_run == 0 || n_strobes > 0, "R2 posted", wr_run, 0);
        release_req();
        repeat (S + R + 4) @(negedge clk);
        chk(last_wr_w == S, "R3 write strobe width", last_wr_w, S);
        chk(last_wdata == wd, "R3 write data", last_wdata, wd);
        chk(last_waddr == bk && !addr_bad, "R10 write addr", last_waddr, bk);
      end else begin
        chk(n == S + 2, "R5 read ack latency", n, S + 2);
        chk(rdata == di, "R5 read data", rdata, di);
        chk(last_rd_w == S, "R4 read strobe width", last_rd_w, S);
        chk(last_raddr == bk && !addr_bad, "R10 read addr", last_raddr, bk);
        release_req();
        chk(rdata == di, "R5 read data held", rdata, di);
        repeat (R + 4) @(negedge clk);
      end
    end

    // R7: read raised right after a posted write
    access(1'b1, 6'd5, 8'h5A, 8'h00, n);
    chk(n == 2, "R2 write ack before stall", n, 2);
    req_valid = 1'b0;
    @(negedge clk);
    access(1'b0, 6'd6, 8'h00, 8'h77, n);
    chk(n == 2 * S + R + 1, "R7 stalled read latency", n, 2 * S + R + 1);
    chk(rdata == 8'h77, "R7 stalled read data", rdata, 8'h77);
    release_req();
    repeat (R + 4) @(negedge clk);
    chk(min_gap >= R, "R6 recovery gap", min_gap, R);
    chk(oe_bad == 0, "R4 doe outside write strobe", oe_bad, 0);

    // R9: reset during posted write
    access(1'b1, 6'd9, 8'h99, 8'h00, n);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(io_wr_n == 1'b0, "R9 strobe running", io_wr_n, 0);
    rst_n = 1'b0;
    #1;
    chk(io_wr_n && !io_doe && !ack, "R9 reset releases bus", {io_wr_n, io_doe, ack}, 3'b100);
    snap = n_strobes;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (S + R + 8) @(negedge clk);
    chk(n_strobes == snap, "R9 posted write dropped", n_strobes, snap);
    chk(io_wr_n && io_rd_n, "R9 bus idle", {io_wr_n, io_rd_n}, 2'b11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule